// File: doc/BRIEF.md
# Receive Destination-Address Filter

This block screens incoming Ethernet frames by their 48-bit destination address. Each frame is presented as one word holding the six address bytes, together with a one-cycle strobe. One clock later the block returns a verdict: whether the frame is accepted, which rule admitted it, and the 6-bit multicast bin index computed from the address.

Four rules are checked in a fixed priority. Promiscuous mode admits everything. The all-ones broadcast address is handled by its own enable. Other group addresses are looked up in a 64-bin table. Unicast frames are compared with a programmed station address. The multicast bin is not taken from a CRC. It is an XOR fold of shifted copies of the six address bytes, so a software hash routine that follows the same fold can fill the table.

The block has no internal configuration state. The enables, the station address and the two table words are static inputs owned by the surrounding register file. They are sampled in the same cycle as the strobe.

Top module: `addr_gate`

## Requirements
- R1: `out_vld` is high exactly one cycle after each cycle in which `in_vld` is high. The verdict outputs change only in that cycle and hold their values while no strobe arrives.
- R2: `out_hash` is the low 6 bits of the XOR of six terms, where address byte k sits in `in_dst[8k+7:8k]`. For bytes 0 and 3 the term is (b>>2)^(b<<4). For bytes 1 and 4 it is (b>>4)^(b<<2). For bytes 2 and 5 it is (b>>6)^b.
- R3: A bin index below 32 selects bit `index` of `cfg_hash_lo`. An index of 32 or more selects bit `index-32` of `cfg_hash_hi`.
- R4: When `cfg_promisc` is 1, every frame is accepted with class 4. This overrides all other settings.
- R5: A destination of all 48 ones is broadcast. Without promiscuous mode it is accepted with class 2 when `cfg_bcast_en` is 1, and rejected otherwise. The hash table is never consulted for it.
- R6: A non-broadcast address with bit 0 of byte 0 set is multicast. It is accepted with class 3 only when `cfg_mcast_en` is 1 and its table bin is set, and rejected otherwise.
- R7: Any other address is unicast. It is accepted with class 1 only when `cfg_ucast_en` is 1 and it equals the station address, and rejected otherwise. The station address is formed from byte 0..3 in `cfg_sta_lo` (byte 0 in bits 7:0), byte 4 in `cfg_sta_b4` and byte 5 in `cfg_sta_b5`.
- R8: `out_class` codes are 0 reject, 1 unicast, 2 broadcast, 3 multicast hit and 4 promiscuous. `out_accept` is 1 exactly when the class is non-zero.
- R9: With both table words all ones and `cfg_mcast_en` set, every multicast frame is accepted with class 3.
- R10: After reset, `out_vld`, `out_accept`, `out_class` and `out_hash` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Destination address strobe |
| in_dst | input | 48 | Destination address, byte k in bits 8k+7:8k |
| cfg_promisc | input | 1 | Accept every frame |
| cfg_bcast_en | input | 1 | Accept broadcast |
| cfg_mcast_en | input | 1 | Accept multicast whose bin is set |
| cfg_ucast_en | input | 1 | Accept unicast matching the station address |
| cfg_sta_lo | input | 32 | Station address bytes 0..3 |
| cfg_sta_b4 | input | 8 | Station address byte 4 |
| cfg_sta_b5 | input | 8 | Station address byte 5 |
| cfg_hash_lo | input | 32 | Bins 0..31 |
| cfg_hash_hi | input | 32 | Bins 32..63 |
| out_vld | output | 1 | Verdict valid |
| out_accept | output | 1 | Frame accepted |
| out_class | output | 3 | Match class |
| out_hash | output | 6 | Computed bin index |

## Verification
The only state in the block is the verdict register, so an internal fault shows at the ports in the cycle right after the strobe. A fault in the fold term of one byte shows as a wrong `out_hash`. A wrong bin selection or priority shows as a wrong class or accept flag for that frame. A register that updates without a strobe is caught one cycle later by the hold check. The priority order between broadcast, multicast and unicast is exercised with addresses that sit on the boundaries: the all-ones address, a single group bit set, and the station address with one bit flipped.

// File: rtl/addr_gate_pkg.sv
package addr_gate_pkg;

    localparam int BYTE_W   = 8;
    localparam int NBYTES   = 6;
    localparam int ADDR_W   = BYTE_W * NBYTES;
    localparam int BIN_W    = 6;
    localparam int WORD_W   = 32;
    localparam int NBINS    = 1 << BIN_W;
    localparam int NWORDS   = NBINS / WORD_W;

    typedef enum logic [2:0] {
        CLS_REJECT  = 3'd0,
        CLS_UNICAST = 3'd1,
        CLS_BCAST   = 3'd2,
        CLS_MHASH   = 3'd3,
        CLS_PROMISC = 3'd4
    } match_cls_e;

    typedef struct packed {
        logic             accept;
        match_cls_e       cls;
        logic [BIN_W-1:0] bin;
    } verdict_t;

    // Per-byte fold term; the shift pattern repeats every three bytes.
    function automatic logic [BIN_W-1:0] fold_term(input logic [BYTE_W-1:0] b,
                                                   input int pos);
        logic [BYTE_W-1:0] t;
        case (pos % 3)
            0:       t = (b >> 2) ^ (b << 4);
            1:       t = (b >> 4) ^ (b << 2);
            default: t = (b >> 6) ^ b;
        endcase
        return t[BIN_W-1:0];
    endfunction

endpackage

// File: rtl/addr_gate_fold.sv
module addr_gate_fold
    import addr_gate_pkg::*;
(
    input  logic [ADDR_W-1:0] dst,
    output logic [BIN_W-1:0]  bin
);
    logic [BIN_W-1:0] terms [NBYTES];

    for (genvar k = 0; k < NBYTES; k++) begin : g_term
        assign terms[k] = fold_term(dst[k*BYTE_W +: BYTE_W], k);
    end

    always_comb begin
        bin = '0;
        for (int k = 0; k < NBYTES; k++) begin
            bin = bin ^ terms[k];
        end
    end
endmodule

// File: rtl/addr_gate_bins.sv
module addr_gate_bins
    import addr_gate_pkg::*;
(
    input  logic [BIN_W-1:0]  bin,
    input  logic [WORD_W-1:0] tbl_lo,
    input  logic [WORD_W-1:0] tbl_hi,
    output logic              hit
);
    localparam int SEL_W = BIN_W - $clog2(WORD_W);

    logic [WORD_W-1:0] words [NWORDS];
    logic [SEL_W-1:0]  wsel;
    logic [$clog2(WORD_W)-1:0] bsel;

    assign words[0] = tbl_lo;
    assign words[1] = tbl_hi;
    assign wsel = bin[BIN_W-1 -: SEL_W];
    assign bsel = bin[$clog2(WORD_W)-1:0];

    always_comb begin
        hit = 1'b0;
        for (int w = 0; w < NWORDS; w++) begin
            if (wsel == SEL_W'(w)) hit = words[w][bsel];
        end
    end
endmodule

// File: rtl/addr_gate_decide.sv
module addr_gate_decide
    import addr_gate_pkg::*;
(
    input  logic [ADDR_W-1:0] dst,
    input  logic [ADDR_W-1:0] station,
    input  logic              promisc,
    input  logic              bcast_en,
    input  logic              mcast_en,
    input  logic              ucast_en,
    input  logic              bin_hit,
    output logic              accept,
    output match_cls_e        cls
);
    logic is_bcast;
    logic is_group;
    logic is_mine;

    assign is_bcast = &dst;
    assign is_group = dst[0];
    assign is_mine  = (dst == station);

    always_comb begin
        accept = 1'b0;
        cls    = CLS_REJECT;
        if (promisc) begin
            accept = 1'b1;
            cls    = CLS_PROMISC;
        end else if (is_bcast) begin
            if (bcast_en) begin
                accept = 1'b1;
                cls    = CLS_BCAST;
            end
        end else if (is_group) begin
            if (mcast_en && bin_hit) begin
                accept = 1'b1;
                cls    = CLS_MHASH;
            end
        end else if (ucast_en && is_mine) begin
            accept = 1'b1;
            cls    = CLS_UNICAST;
        end
    end
endmodule

// File: rtl/addr_gate.sv
module addr_gate
    import addr_gate_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [47:0]       in_dst,
    input  logic              cfg_promisc,
    input  logic              cfg_bcast_en,
    input  logic              cfg_mcast_en,
    input  logic              cfg_ucast_en,
    input  logic [31:0]       cfg_sta_lo,
    input  logic [7:0]        cfg_sta_b4,
    input  logic [7:0]        cfg_sta_b5,
    input  logic [31:0]       cfg_hash_lo,
    input  logic [31:0]       cfg_hash_hi,
    output logic              out_vld,
    output logic              out_accept,
    output logic [2:0]        out_class,
    output logic [5:0]        out_hash
);
    logic [ADDR_W-1:0] station;
    logic [BIN_W-1:0]  bin;
    logic              bin_hit;
    verdict_t          nxt;
    verdict_t          cur;
    logic              vld_q;

    assign station = {cfg_sta_b5, cfg_sta_b4, cfg_sta_lo};

    addr_gate_fold u_fold (
        .dst (in_dst),
        .bin (bin)
    );

    addr_gate_bins u_bins (
        .bin    (bin),
        .tbl_lo (cfg_hash_lo),
        .tbl_hi (cfg_hash_hi),
        .hit    (bin_hit)
    );

    addr_gate_decide u_decide (
        .dst      (in_dst),
        .station  (station),
        .promisc  (cfg_promisc),
        .bcast_en (cfg_bcast_en),
        .mcast_en (cfg_mcast_en),
        .ucast_en (cfg_ucast_en),
        .bin_hit  (bin_hit),
        .accept   (nxt.accept),
        .cls      (nxt.cls)
    );

    assign nxt.bin = bin;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            cur   <= '0;
        end else begin
            vld_q <= in_vld;
            if (in_vld) cur <= nxt;
        end
    end

    assign out_vld    = vld_q;
    assign out_accept = cur.accept;
    assign out_class  = cur.cls;
    assign out_hash   = cur.bin;
endmodule

// File: rtl/addr_gate_chk.sv
module addr_gate_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_vld,
    input logic [47:0] in_dst,
    input logic        cfg_promisc,
    input logic        cfg_bcast_en,
    input logic        cfg_mcast_en,
    input logic        cfg_ucast_en,
    input logic [47:0] station,
    input logic        out_vld,
    input logic        out_accept,
    input logic [2:0]  out_class,
    input logic [5:0]  out_hash
);
    // R1: verdict one cycle after strobe
    a_r1_vld_follows: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    // R1: outputs hold without a strobe
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(out_class) && $stable(out_hash) && $stable(out_accept)));

    // R4: promiscuous overrides everything
    a_r4_promisc: assert property (@(posedge clk) disable iff (rst)
        (in_vld && cfg_promisc) |=> (out_accept && out_class == 3'd4));

    // R5: broadcast without enable is rejected
    a_r5_bcast_off: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !cfg_promisc && (&in_dst) && !cfg_bcast_en) |=> !out_accept);

    // R6: multicast without enable is rejected
    a_r6_mcast_off: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !cfg_promisc && !(&in_dst) && in_dst[0] && !cfg_mcast_en) |=> !out_accept);

    // R7: enabled station match is accepted as unicast
    a_r7_station: assert property (@(posedge clk) disable iff (rst)
        (in_vld && !cfg_promisc && !in_dst[0] && cfg_ucast_en && in_dst == station)
        |=> (out_accept && out_class == 3'd1));

    // R8: accept agrees with the class code
    a_r8_accept_cls: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> (out_accept == (out_class != 3'd0)));
endmodule

bind addr_gate addr_gate_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_vld       (in_vld),
    .in_dst       (in_dst),
    .cfg_promisc  (cfg_promisc),
    .cfg_bcast_en (cfg_bcast_en),
    .cfg_mcast_en (cfg_mcast_en),
    .cfg_ucast_en (cfg_ucast_en),
    .station      (station),
    .out_vld      (out_vld),
    .out_accept   (out_accept),
    .out_class    (out_class),
    .out_hash     (out_hash)
);

// File: tb/sim_addr_gate.sv
module sim_addr_gate;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [47:0] in_dst = '0;
    logic        cfg_promisc = 1'b0, cfg_bcast_en = 1'b0, cfg_mcast_en = 1'b0, cfg_ucast_en = 1'b0;
    logic [31:0] cfg_sta_lo = '0;
    logic [7:0]  cfg_sta_b4 = '0, cfg_sta_b5 = '0;
    logic [31:0] cfg_hash_lo = '0, cfg_hash_hi = '0;
    logic        out_vld, out_accept;
    logic [2:0]  out_class;
    logic [5:0]  out_hash;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    addr_gate u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_dst(in_dst),
        .cfg_promisc(cfg_promisc), .cfg_bcast_en(cfg_bcast_en),
        .cfg_mcast_en(cfg_mcast_en), .cfg_ucast_en(cfg_ucast_en),
        .cfg_sta_lo(cfg_sta_lo), .cfg_sta_b4(cfg_sta_b4), .cfg_sta_b5(cfg_sta_b5),
        .cfg_hash_lo(cfg_hash_lo), .cfg_hash_hi(cfg_hash_hi),
        .out_vld(out_vld), .out_accept(out_accept),
        .out_class(out_class), .out_hash(out_hash)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] sta();
        return {cfg_sta_b5, cfg_sta_b4, cfg_sta_lo};
    endfunction

    // Byte-wise fold written from the requirement, 32-bit arithmetic then masked.
    function automatic int ref_hash(input logic [47:0] a);
        int h;
        int b [6];
        for (int k = 0; k < 6; k++) b[k] = int'(a[8*k +: 8]);
        h = 0;
        h ^= (b[0] >> 2) ^ (b[0] << 4);
        h ^= (b[1] >> 4) ^ (b[1] << 2);
        h ^= (b[2] >> 6) ^ b[2];
        h ^= (b[3] >> 2) ^ (b[3] << 4);
        h ^= (b[4] >> 4) ^ (b[4] << 2);
        h ^= (b[5] >> 6) ^ b[5];
        return h & 63;
    endfunction

    function automatic logic bin_set(input int h);
        if (h < 32) return cfg_hash_lo[h];
        return cfg_hash_hi[h - 32];
    endfunction

    function automatic int ref_cls(input logic [47:0] a);
        if (cfg_promisc) return 4;
        if (a == 48'hFFFF_FFFF_FFFF) return cfg_bcast_en ? 2 : 0;
        if (a[0]) return (cfg_mcast_en && bin_set(ref_hash(a))) ? 3 : 0;
        return (cfg_ucast_en && a == sta()) ? 1 : 0;
    endfunction

    function automatic string path_tag(input logic [47:0] a);
        if (cfg_promisc) return "R4";
        if (a == 48'hFFFF_FFFF_FFFF) return "R5";
        if (a[0]) return "R6";
        return "R7";
    endfunction

    // Present one address, check the verdict, then check that it holds.
    task automatic send(input logic [47:0] a, input string tag);
        int ec, eh;
        string pt;
        ec = ref_cls(a);
        eh = ref_hash(a);
        pt = path_tag(a);
        @(negedge clk);
        in_dst = a;
        in_vld = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        in_dst = ~a;
        chk("R1 out_vld pulse", 32'(out_vld), 32'd1);
        chk({"R2 hash ", tag}, 32'(out_hash), 32'(eh));
        chk({pt, " class ", tag}, 32'(out_class), 32'(ec));
        chk("R8 accept", 32'(out_accept), 32'(ec != 0));
        @(negedge clk);
        chk("R1 out_vld low", 32'(out_vld), 32'd0);
        chk("R1 class hold", 32'(out_class), 32'(ec));
        chk("R1 hash hold", 32'(out_hash), 32'(eh));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [47:0] a;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 vld", 32'(out_vld), 0);
        chk("R10 accept", 32'(out_accept), 0);
        chk("R10 class", 32'(out_class), 0);
        chk("R10 hash", 32'(out_hash), 0);
        rst = 1'b0;

        cfg_sta_lo = 32'h4433_2210; cfg_sta_b4 = 8'h55; cfg_sta_b5 = 8'h66;

        // R2: hand-worked fold, 01:00:5E:00:00:01 -> bin 14
        cfg_mcast_en = 1'b1;
        cfg_hash_lo = 32'h0000_4000;
        send(48'h01_00_00_5E_00_01, "R2 known");
        chk("R2 known bin 14", 32'(out_hash), 32'd14);
        chk("R3 low word bit14 class", 32'(out_class), 32'd3);
        // R3: same bin set only in high word -> reject
        cfg_hash_lo = 32'h0; cfg_hash_hi = 32'h0000_4000;
        send(48'h01_00_00_5E_00_01, "R3 hi only");
        chk("R3 high word bit14 miss", 32'(out_accept), 32'd0);
        // R3: byte0 = 0x03 -> bin 48, high word bit 16
        cfg_hash_hi = 32'h0001_0000;
        send(48'h00_00_00_00_00_03, "R3 bin48");
        chk("R3 bin48 via high word", 32'(out_class), 32'd3);
        cfg_hash_hi = 32'h0;
        cfg_hash_lo = 32'h0001_0000;
        send(48'h00_00_00_00_00_03, "R3 bin48 lo");
        chk("R3 bin48 low word ignored", 32'(out_accept), 32'd0);

        // R5: broadcast with table all ones but bcast disabled
        cfg_hash_lo = '1; cfg_hash_hi = '1; cfg_bcast_en = 1'b0;
        send(48'hFFFF_FFFF_FFFF, "R5 off");
        chk("R5 broadcast not hashed", 32'(out_class), 32'd0);
        cfg_bcast_en = 1'b1;
        send(48'hFFFF_FFFF_FFFF, "R5 on");
        chk("R5 broadcast on", 32'(out_class), 32'd2);

        // R9: all-ones table accepts arbitrary multicast
        for (int i = 0; i < 8; i++) begin
            a = {$urandom(), $urandom()};
            a[0] = 1'b1;
            a[47] = 1'b0;
            send(a, "R9");
            chk("R9 all-ones table", 32'(out_class), 32'd3);
        end

        // R7: station match, one bit off, and disabled
        cfg_ucast_en = 1'b1;
        send(sta(), "R7 match");
        chk("R7 station accepted", 32'(out_class), 32'd1);
        send(sta() ^ 48'h0100_0000_0000, "R7 near");
        chk("R7 near miss", 32'(out_accept), 32'd0);
        cfg_ucast_en = 1'b0;
        send(sta(), "R7 disabled");
        chk("R7 disabled", 32'(out_accept), 32'd0);

        // R4: promiscuous with everything else off
        cfg_promisc = 1'b1; cfg_bcast_en = 1'b0; cfg_mcast_en = 1'b0;
        cfg_hash_lo = '0; cfg_hash_hi = '0;
        send(48'h1234_5678_9ABC, "R4");
        chk("R4 promisc", 32'(out_class), 32'd4);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int kind;
            cfg_promisc  = ($urandom % 6) == 0;
            cfg_bcast_en = $urandom % 2;
            cfg_mcast_en = $urandom % 2;
            cfg_ucast_en = $urandom % 2;
            cfg_hash_lo  = (($urandom % 8) == 0) ? '1 : $urandom();
            cfg_hash_hi  = (($urandom % 8) == 0) ? '1 : $urandom();
            kind = $urandom % 5;
            case (kind)
                0: a = sta();
                1: a = 48'hFFFF_FFFF_FFFF;
                2: begin a = {$urandom(), $urandom()}; a[0] = 1'b1; end
                3: begin a = {$urandom(), $urandom()}; a[0] = 1'b0; end
                default: a = sta() ^ (48'd1 << (1 + ($urandom % 47)));
            endcase
            send(a, "random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule